// File: doc/BRIEF.md
# Power-Up Sequencing Controller

This controller takes a chip from the moment its main supply is applied to the moment firmware may run. Until a wake request arrives the core regulator stays off. A request may come from either of two pins, one active high and one active low. The request turns on the regulator, and the controller then waits for the regulator's supply-good comparator. Supply-good counts as accepted only after it has stayed high for a set number of slow settle-tick pulses.

After the supply is accepted, the controller drops the core-supply reset but keeps the system reset asserted while an outside calibration loader fetches regulator, monitor and oscillator trim values. Once the loader signals completion, a calibration-valid flag rises. On the next clock the system reset is released, and one clock after that the port-configuration enable is raised. If supply-good falls at any point after wake-up, the controller returns to waiting for the regulator with every reset asserted.

The states are OFF, regulator-wait, settle, calibration-load and run. Each transition takes effect one clock after the condition that qualifies it.

Top module: `pwrup_seq_ctrl`

## Requirements
- R1: After synchronous reset the controller is off: `vreg_en`=0, `core_rst`=1, `sys_rst`=1, `calib_valid`=0, `port_cfg_en`=0. While off, `vreg_good`, `settle_tick` and `calib_done` have no effect on any output.
- R2: While off, `wake_hi`=1 or `wake_lo_n`=0 sets `vreg_en` to 1 on the next clock. Either pin alone is enough.
- R3: `core_rst` stays 1 from reset until supply-good has been accepted. It never falls in a cycle that follows a low `vreg_good`.
- R4: After `vreg_good` is first seen high while the regulator is on, supply-good is accepted once SETTLE_TICKS clock edges have sampled `settle_tick`=1 with `vreg_good` high throughout. Ticks sampled before that first high sample are not counted. `core_rst` falls on the clock after the edge that samples the last tick.
- R5: `sys_rst` stays 1 through the calibration-load phase for as long as `calib_done` has not been sampled, however long that takes.
- R6: `calib_valid` rises one clock after `calib_done` is sampled during calibration load. `sys_rst` falls one clock after `calib_valid` rises.
- R7: `port_cfg_en` rises one clock after `sys_rst` falls.
- R8: When `vreg_good` is sampled low in any state other than off, the next clock gives `vreg_en`=1, `core_rst`=1, `sys_rst`=1, `calib_valid`=0 and `port_cfg_en`=0, and the settle count starts again from zero.
- R9: `calib_done` sampled outside calibration load leaves `calib_valid` at 0. The wake pins have no effect once the regulator is on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wake_hi | input | 1 | Wake request, active high |
| wake_lo_n | input | 1 | Wake request, active low |
| vreg_good | input | 1 | Core regulator output above its threshold |
| calib_done | input | 1 | Calibration loader finished |
| settle_tick | input | 1 | One-clock pulse from the slow settle timebase |
| vreg_en | output | 1 | Core regulator enable |
| core_rst | output | 1 | Core-supply reset, active high |
| sys_rst | output | 1 | System reset, active high |
| calib_valid | output | 1 | Calibration data available |
| port_cfg_en | output | 1 | Port configuration enable |

## Verification
The bench wakes the controller once from each pin. A design that decoded only one pin would keep the regulator off on the second wake. It drops supply-good partway through the settle count and then lets the supply recover. A design that kept the partial count would release `core_rst` two ticks early. It holds off the calibration handshake for several cycles and pulses `calib_done` once during settling. A design that latched the early pulse would raise `calib_valid` too soon. A design that released `sys_rst` and raised `calib_valid` on the same edge would fail the one-clock ordering check. The bench also drops supply-good after `calib_valid` is set, which exposes a flag that is not cleared on supply loss.

// File: rtl/pwrup_pkg.sv
// Shared types for the power-up sequencer.
// Assumes: states are only ever compared by name, never by encoding.
package pwrup_pkg;
    typedef enum logic [2:0] {
        ST_OFF      = 3'd0,
        ST_REG_WAIT = 3'd1,
        ST_SETTLE   = 3'd2,
        ST_CAL_LOAD = 3'd3,
        ST_RUN      = 3'd4
    } seq_state_t;
endpackage

// File: rtl/pwrup_wake_merge.sv
// Merges the two wake pins into one request.
// Assumes: pins are already synchronous to clk (debounced and synchronised
// outside this block), so the request is used combinationally.
module pwrup_wake_merge (
    input  logic wake_hi,
    input  logic wake_lo_n,
    output logic wake_req
);
    // Either polarity alone raises the request.
    always_comb begin
        wake_req = wake_hi | ~wake_lo_n;
    end
endmodule

// File: rtl/pwrup_settle_timer.sv
// Counts settle-tick pulses while supply-good stays high in the settle phase.
// Assumes: clear is asserted whenever the sequencer is outside the settle
// phase, so every settle interval starts from zero.
module pwrup_settle_timer #(
    parameter int SETTLE_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic count_en,
    input  logic tick,
    output logic done
);
    localparam int CW = $clog2(SETTLE_TICKS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(SETTLE_TICKS);

    logic [CW-1:0] cnt_q;

    // Saturating tick counter, restarted by clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (count_en && tick && (cnt_q != LIMIT)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Interval complete once the limit is reached.
    always_comb begin
        done = (cnt_q == LIMIT);
    end

    // R4
    settle_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIMIT);

    // R8
    settle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0));
endmodule

// File: rtl/pwrup_seq_fsm.sv
// Five-state power-up sequencer: off, regulator wait, settle, calibration
// load, run. Assumes: vreg_good is meaningless while off; any later drop
// sends the sequence back to regulator wait.
module pwrup_seq_fsm
    import pwrup_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wake_req,
    input  logic       vreg_good,
    input  logic       settle_done,
    input  logic       calib_flag,
    output seq_state_t state,
    output logic       supply_lost
);
    seq_state_t state_q, state_d;

    // Supply drop seen in any powered state.
    always_comb begin
        supply_lost = (state_q != ST_OFF) && !vreg_good;
    end

    // Next-state selection, supply loss taking priority.
    always_comb begin
        state_d = state_q;
        if (supply_lost) begin
            state_d = ST_REG_WAIT;
        end else begin
            case (state_q)
                ST_OFF:      if (wake_req)    state_d = ST_REG_WAIT;
                ST_REG_WAIT: if (vreg_good)   state_d = ST_SETTLE;
                ST_SETTLE:   if (settle_done) state_d = ST_CAL_LOAD;
                ST_CAL_LOAD: if (calib_flag)  state_d = ST_RUN;
                ST_RUN:                       state_d = ST_RUN;
                default:                      state_d = ST_OFF;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    assign state = state_q;

    // R2
    off_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF && wake_req) |=> (state_q == ST_REG_WAIT));

    // R6
    run_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && $past(state_q) != ST_RUN) |-> $past(calib_flag));
endmodule

// File: rtl/pwrup_ready_flags.sv
// Holds the calibration-valid and port-enable flags.
// Assumes: supply_lost clears both on the same edge the sequencer falls back.
module pwrup_ready_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic in_cal_load,
    input  logic in_run,
    input  logic calib_done,
    input  logic supply_lost,
    output logic calib_valid,
    output logic port_cfg_en
);
    logic calib_q, port_q;

    // Calibration flag: set by the loader handshake only during loading.
    always_ff @(posedge clk) begin
        if (!rst_n || supply_lost) begin
            calib_q <= 1'b0;
        end else if (in_cal_load && calib_done) begin
            calib_q <= 1'b1;
        end else if (!in_cal_load && !in_run) begin
            calib_q <= 1'b0;
        end
    end

    // Port enable: raised one clock into run.
    always_ff @(posedge clk) begin
        if (!rst_n || supply_lost) begin
            port_q <= 1'b0;
        end else begin
            port_q <= in_run;
        end
    end

    assign calib_valid = calib_q;
    assign port_cfg_en = port_q;

    // R9
    calib_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(calib_q) |-> $past(in_cal_load));
endmodule

// File: rtl/pwrup_seq_ctrl.sv
// Top of the power-up sequencer. Decodes reset and enable outputs from the
// sequencer state and wires the settle timer and ready flags.
// Assumes: settle_tick is a single-clock pulse; all inputs are synchronous.
module pwrup_seq_ctrl
    import pwrup_pkg::*;
#(
    parameter int SETTLE_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wake_hi,
    input  logic wake_lo_n,
    input  logic vreg_good,
    input  logic calib_done,
    input  logic settle_tick,
    output logic vreg_en,
    output logic core_rst,
    output logic sys_rst,
    output logic calib_valid,
    output logic port_cfg_en
);
    logic       wake_req;
    logic       settle_done;
    logic       supply_lost;
    logic       calib_flag;
    seq_state_t state;

    pwrup_wake_merge u_wake (
        .wake_hi   (wake_hi),
        .wake_lo_n (wake_lo_n),
        .wake_req  (wake_req)
    );

    pwrup_settle_timer #(.SETTLE_TICKS(SETTLE_TICKS)) u_settle (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (state != ST_SETTLE),
        .count_en (vreg_good),
        .tick     (settle_tick),
        .done     (settle_done)
    );

    pwrup_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wake_req    (wake_req),
        .vreg_good   (vreg_good),
        .settle_done (settle_done),
        .calib_flag  (calib_flag),
        .state       (state),
        .supply_lost (supply_lost)
    );

    pwrup_ready_flags u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_cal_load (state == ST_CAL_LOAD),
        .in_run      (state == ST_RUN),
        .calib_done  (calib_done),
        .supply_lost (supply_lost),
        .calib_valid (calib_flag),
        .port_cfg_en (port_cfg_en)
    );

    // Output decode straight from the registered state (glitch-free).
    always_comb begin
        vreg_en     = (state != ST_OFF);
        core_rst    = (state == ST_OFF) || (state == ST_REG_WAIT) ||
                      (state == ST_SETTLE);
        sys_rst     = (state != ST_RUN);
        calib_valid = calib_flag;
    end

    // R1
    stay_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!vreg_en && !wake_req) |=> (!vreg_en && !calib_valid && !port_cfg_en));

    // R2
    wake_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!vreg_en && wake_req) |=> vreg_en);

    // R3
    core_rst_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_rst) |-> $past(vreg_good));

    // R4
    core_rst_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_rst) |-> $past(settle_done));

    // R6
    sys_rst_after_cal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst) |-> (calib_valid && $past(calib_valid)));

    // R6
    cal_before_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(calib_valid) |-> (sys_rst && $past(calib_done)));

    // R7
    port_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(port_cfg_en) |-> (!sys_rst && $past(!sys_rst)));

    // R8
    supply_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vreg_en && !vreg_good) |=>
            (vreg_en && core_rst && sys_rst && !calib_valid && !port_cfg_en));
endmodule

// File: tb/sim_pwrup_seq_ctrl.sv
module sim_pwrup_seq_ctrl;
    localparam int TICKS  = 3;
    localparam int N_ROWS = 37;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wake_hi = 1'b0, wake_lo_n = 1'b1, vreg_good = 1'b0;
    logic calib_done = 1'b0, settle_tick = 1'b0;
    logic vreg_en, core_rst, sys_rst, calib_valid, port_cfg_en;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    pwrup_seq_ctrl #(.SETTLE_TICKS(TICKS)) u0 (
        .clk(clk), .rst_n(rst_n), .wake_hi(wake_hi), .wake_lo_n(wake_lo_n),
        .vreg_good(vreg_good), .calib_done(calib_done), .settle_tick(settle_tick),
        .vreg_en(vreg_en), .core_rst(core_rst), .sys_rst(sys_rst),
        .calib_valid(calib_valid), .port_cfg_en(port_cfg_en)
    );

    // Row: {req[3:0], rst_n wake_hi wake_lo_n vreg_good calib_done settle_tick,
    //       expected vreg_en core_rst sys_rst calib_valid port_cfg_en}
    localparam logic [14:0] VEC [N_ROWS] = '{
        {4'd1, 6'b101111, 5'b01100},  // R1 inputs ignored while off
        {4'd2, 6'b111000, 5'b11100},  // R2 high pin wakes
        {4'd4, 6'b101001, 5'b11100},  // R4 tick in regulator wait not counted
        {4'd3, 6'b101100, 5'b11100},  // R3 good seen, enter settle
        {4'd9, 6'b101111, 5'b11100},  // R9 early calib_done, tick 1
        {4'd4, 6'b101101, 5'b11100},  // R4 tick 2
        {4'd4, 6'b101100, 5'b11100},  // R4 no tick
        {4'd3, 6'b101101, 5'b11100},  // R3 tick 3, still in reset
        {4'd4, 6'b101100, 5'b10100},  // R4 core reset falls
        {4'd5, 6'b101100, 5'b10100},  // R5 waiting for loader
        {4'd5, 6'b101100, 5'b10100},  // R5 delayed handshake
        {4'd6, 6'b101110, 5'b10110},  // R6 calib_valid rises
        {4'd6, 6'b101100, 5'b10010},  // R6 system reset falls
        {4'd7, 6'b101100, 5'b10011},  // R7 port enable rises
        {4'd9, 6'b110111, 5'b10011},  // R9 pins ignored in run
        {4'd8, 6'b101000, 5'b11100},  // R8 drop in run
        {4'd1, 6'b001000, 5'b01100},  // R1 reset back to off
        {4'd2, 6'b100000, 5'b11100},  // R2 low pin wakes
        {4'd3, 6'b101100, 5'b11100},  // R3 enter settle
        {4'd4, 6'b101101, 5'b11100},  // R4 tick 1
        {4'd4, 6'b101101, 5'b11100},  // R4 tick 2
        {4'd8, 6'b101000, 5'b11100},  // R8 glitch during settle
        {4'd8, 6'b101100, 5'b11100},  // R8 settle restarts
        {4'd8, 6'b101101, 5'b11100},  // R8 tick 1
        {4'd8, 6'b101101, 5'b11100},  // R8 tick 2, stale count would release
        {4'd4, 6'b101101, 5'b11100},  // R4 tick 3
        {4'd4, 6'b101100, 5'b10100},  // R4 core reset falls
        {4'd6, 6'b101110, 5'b10110},  // R6 calib_valid rises
        {4'd8, 6'b101000, 5'b11100},  // R8 drop clears calib_valid
        {4'd3, 6'b101100, 5'b11100},  // R3 settle again
        {4'd4, 6'b101101, 5'b11100},  // R4 tick 1
        {4'd4, 6'b101101, 5'b11100},  // R4 tick 2
        {4'd4, 6'b101101, 5'b11100},  // R4 tick 3
        {4'd4, 6'b101100, 5'b10100},  // R4 core reset falls
        {4'd6, 6'b101110, 5'b10110},  // R6 calib_valid rises
        {4'd6, 6'b101100, 5'b10010},  // R6 system reset falls
        {4'd7, 6'b101100, 5'b10011}   // R7 port enable rises
    };

    task automatic check(input string tag, input logic [4:0] got, input logic [4:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: outputs %b expected %b", tag, got, exp);
        end
    endtask

    function automatic logic [4:0] outs();
        return {vreg_en, core_rst, sys_rst, calib_valid, port_cfg_en};
    endfunction

    initial begin
        // R1 reset state
        repeat (3) @(posedge clk);
        #5 check("R1 reset state", outs(), 5'b01100);
        for (int i = 0; i < N_ROWS; i++) begin
            @(negedge clk);
            {rst_n, wake_hi, wake_lo_n, vreg_good, calib_done, settle_tick} = VEC[i][10:5];
            @(posedge clk);
            #5 check($sformatf("row %0d R%0d", i, VEC[i][14:11]), outs(), VEC[i][4:0]);
        end
        // R5 long hold: sys_rst stays set while loader is slow
        @(negedge clk); {rst_n, wake_hi, wake_lo_n, vreg_good, calib_done, settle_tick} = 6'b001000;
        @(negedge clk); {rst_n, wake_hi, wake_lo_n, vreg_good} = 4'b1100;
        @(negedge clk); {wake_hi, vreg_good} = 2'b01;
        for (int t = 0; t < TICKS; t++) begin
            @(negedge clk); settle_tick = 1'b1;
        end
        @(negedge clk); settle_tick = 1'b0;
        repeat (20) @(posedge clk);
        #5 check("R5 long calibration wait", outs(), 5'b10100);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, got %b expected done", outs());
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule